// File: doc/BRIEF.md
# Source Operand Addressing Sequencer

This unit resolves the source operand of a 16-bit two-operand instruction. A decoder hands it a source register number, a 2-bit addressing mode and a byte/word flag with a one-cycle start pulse. The unit reads the register file, issues word reads on a simple synchronous memory port, and raises a one-cycle done strobe with the operand value.

Along the way it generates program-counter updates for extension-word fetches and immediates. It also generates register-file updates for auto-increment. Register numbers 2 and 3 can select hardwired constants, which need no memory traffic. When register 0 or 2 is combined with the indexed or auto-increment modes, the unit forms PC-relative, absolute and immediate operands.

The memory port returns read data in the cycle after a request. Register reads are combinational: the unit drives a read index and samples the returned value in the start cycle. The program counter value is taken from its own input at start.

Top module: `sopnd_seq`

## Requirements
- R1: The mode field is decoded as 00 register, 01 indexed, 10 indirect, 11 indirect auto-increment. In register mode the operand is the register value (the PC input for register 0). Done rises one cycle after start, and no memory request is made.
- R2: A byte-mode operand taken from a register or a constant is its low 8 bits, zero-extended to 16 bits.
- R3: Register 3 gives the constants 0, 1, 2 and 0xFFFF for modes 00, 01, 10 and 11. Done comes one cycle after start, with no memory request and no register or PC update.
- R4: Register 2 gives the constant 4 in mode 10 and 8 in mode 11, with no memory access. In mode 00 it returns the register value.
- R5: Indirect mode makes one read at the register value. Done comes two cycles after start, with the operand equal to the memory word.
- R6: A byte-mode operand read from memory is the high byte of the word when address bit 0 is 1, and the low byte otherwise, zero-extended.
- R7: Auto-increment writes the register plus 1 for byte operations and plus 2 for word operations. Registers 0 and 1 always step by 2. The write is issued in the same cycle as the operand read.
- R8: Register 0 in mode 11 is immediate. The word at the PC is the operand, the PC is written with PC+2 in the read cycle, and done comes two cycles after start.
- R9: Indexed mode on a general register fetches an extension word at the PC and writes PC+2 in that cycle. It then reads at the extension word plus the register value, and done comes three cycles after start.
- R10: Register 0 in mode 01 reads at the extension word plus the already advanced PC (original PC + 2).
- R11: Register 2 in mode 01 reads at the extension word alone.
- R12: A start pulse is accepted only while the unit is idle; a start during a sequence is ignored. Done lasts exactly one cycle per accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin resolving a source operand |
| src_reg_i | input | 4 | Source register number |
| src_mode_i | input | 2 | Source addressing mode |
| byte_op_i | input | 1 | 1 for a byte operation |
| pc_i | input | 16 | Current program counter |
| rf_rd_idx_o | output | 4 | Register file read index |
| rf_rd_data_i | input | 16 | Register file read data |
| mem_req_o | output | 1 | Memory word read request |
| mem_addr_o | output | 16 | Memory byte address |
| mem_rdata_i | input | 16 | Memory data, valid the cycle after a request |
| pc_wr_en_o | output | 1 | Program counter write enable |
| pc_wr_data_o | output | 16 | New program counter value |
| rf_wr_en_o | output | 1 | Auto-increment register write enable |
| rf_wr_idx_o | output | 4 | Register written by auto-increment |
| rf_wr_data_o | output | 16 | Incremented register value |
| done_o | output | 1 | Operand valid strobe |
| operand_o | output | 16 | Resolved source operand |

## Verification
The assertions watch every cycle for several rules. Constant selections must finish in one cycle with no memory request. Every PC write must go with a read at the old PC. Every auto-increment write must step the read address by the allowed amount, in the same cycle as the read. An accepted indexed start must be followed by an extension fetch, and done must never last two cycles or overlap a request. Operand values can only be shown by the bench's scenarios: byte-lane selection, the three effective-address bases for indexed forms, exact latencies per mode, and the ignored start during a sequence.

// File: rtl/sopnd_pkg.sv
package sopnd_pkg;

  typedef enum logic [1:0] {
    AM_REG = 2'b00,
    AM_IDX = 2'b01,
    AM_IND = 2'b10,
    AM_INC = 2'b11
  } amode_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_EXT,
    S_READ,
    S_DONE
  } seq_state_e;

  localparam int PC_NUM = 0;
  localparam int SP_NUM = 1;
  localparam int SR_NUM = 2;
  localparam int CG_NUM = 3;

endpackage

// File: rtl/sopnd_cgen.sv
module sopnd_cgen
  import sopnd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic [IDX_W-1:0]  reg_idx,
  input  amode_e            mode,
  output logic              is_const,
  output logic [DATA_W-1:0] const_val
);

  logic sel_r2;
  logic sel_r3;

  always_comb begin
    sel_r3    = (reg_idx == IDX_W'(CG_NUM));
    sel_r2    = (reg_idx == IDX_W'(SR_NUM)) && mode[1];
    is_const  = sel_r3 || sel_r2;
    const_val = '0;
    if (sel_r3) begin
      case (mode)
        AM_REG:  const_val = DATA_W'(0);
        AM_IDX:  const_val = DATA_W'(1);
        AM_IND:  const_val = DATA_W'(2);
        default: const_val = '1;
      endcase
    end else if (sel_r2) begin
      const_val = (mode == AM_IND) ? DATA_W'(4) : DATA_W'(8);
    end
  end

endmodule

// File: rtl/sopnd_agu.sv
module sopnd_agu
  import sopnd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic              byte_op,
  input  logic [DATA_W-1:0] rs_val,
  input  logic [DATA_W-1:0] pc_val,
  input  logic [DATA_W-1:0] ext_word,
  output logic [DATA_W-1:0] idx_ea,
  output logic [DATA_W-1:0] inc_val
);

  localparam int WORD_BYTES = DATA_W / 8;

  logic [DATA_W-1:0] base;
  logic [DATA_W-1:0] step;
  logic              wide_reg;

  always_comb begin
    if (reg_idx == IDX_W'(PC_NUM))      base = pc_val;
    else if (reg_idx == IDX_W'(SR_NUM)) base = '0;
    else                                base = rs_val;
    idx_ea = ext_word + base;

    wide_reg = (reg_idx == IDX_W'(PC_NUM)) || (reg_idx == IDX_W'(SP_NUM));
    step     = (byte_op && !wide_reg) ? DATA_W'(1) : DATA_W'(WORD_BYTES);
    inc_val  = rs_val + step;
  end

endmodule

// File: rtl/sopnd_bytesel.sv
module sopnd_bytesel #(
  parameter int DATA_W = 16
) (
  input  logic              byte_op,
  input  logic              addr_lsb,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] value
);

  logic [7:0] lane;

  always_comb begin
    lane  = addr_lsb ? word[15:8] : word[7:0];
    value = byte_op ? {{(DATA_W-8){1'b0}}, lane} : word;
  end

endmodule

// File: rtl/sopnd_seq.sv
module sopnd_seq
  import sopnd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  src_reg_i,
  input  logic [1:0]        src_mode_i,
  input  logic              byte_op_i,
  input  logic [DATA_W-1:0] pc_i,
  output logic [IDX_W-1:0]  rf_rd_idx_o,
  input  logic [DATA_W-1:0] rf_rd_data_i,
  output logic              mem_req_o,
  output logic [DATA_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              pc_wr_en_o,
  output logic [DATA_W-1:0] pc_wr_data_o,
  output logic              rf_wr_en_o,
  output logic [IDX_W-1:0]  rf_wr_idx_o,
  output logic [DATA_W-1:0] rf_wr_data_o,
  output logic              done_o,
  output logic [DATA_W-1:0] operand_o
);

  localparam int WORD_BYTES = DATA_W / 8;

  seq_state_e        state_q, state_d;
  logic [IDX_W-1:0]  reg_q;
  amode_e            mode_q;
  logic              byte_q;
  logic              idx_q;
  logic              mem_q;
  logic              lsb_q;
  logic [DATA_W-1:0] rs_q;
  logic [DATA_W-1:0] pc_q;
  logic [DATA_W-1:0] val_q;

  logic              cap_en, ext_en, rd_en;
  logic              idle_w;
  amode_e            mode_in;
  logic [DATA_W-1:0] rs_val_w;
  logic              cg_hit;
  logic [DATA_W-1:0] cg_val;
  logic [DATA_W-1:0] ea_w;
  logic [DATA_W-1:0] inc_w;
  logic [DATA_W-1:0] rd_addr_w;
  logic [DATA_W-1:0] sel_word_w;
  logic [DATA_W-1:0] sel_val_w;

  assign mode_in     = amode_e'(src_mode_i);
  assign rf_rd_idx_o = src_reg_i;
  assign rs_val_w    = (src_reg_i == IDX_W'(PC_NUM)) ? pc_i : rf_rd_data_i;
  assign idle_w      = (state_q == S_IDLE);

  sopnd_cgen #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_cgen (
    .reg_idx   (src_reg_i),
    .mode      (mode_in),
    .is_const  (cg_hit),
    .const_val (cg_val)
  );

  sopnd_agu #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_agu (
    .reg_idx  (reg_q),
    .byte_op  (byte_q),
    .rs_val   (rs_q),
    .pc_val   (pc_q),
    .ext_word (mem_rdata_i),
    .idx_ea   (ea_w),
    .inc_val  (inc_w)
  );

  assign sel_word_w = mem_q ? mem_rdata_i : val_q;

  sopnd_bytesel #(.DATA_W(DATA_W)) u_bsel (
    .byte_op  (byte_q),
    .addr_lsb (mem_q & lsb_q),
    .word     (sel_word_w),
    .value    (sel_val_w)
  );

  assign rd_addr_w = idx_q ? ea_w : rs_q;

  // next-state logic
  always_comb begin
    state_d = state_q;
    cap_en  = 1'b0;
    ext_en  = 1'b0;
    rd_en   = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (start_i) begin
          cap_en = 1'b1;
          if (cg_hit || mode_in == AM_REG) state_d = S_DONE;
          else if (mode_in == AM_IDX)      state_d = S_EXT;
          else                             state_d = S_READ;
        end
      end
      S_EXT: begin
        ext_en  = 1'b1;
        state_d = S_READ;
      end
      S_READ: begin
        rd_en   = 1'b1;
        state_d = S_DONE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  // captured operand context
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q  <= '0;
      mode_q <= AM_REG;
      byte_q <= 1'b0;
      idx_q  <= 1'b0;
      mem_q  <= 1'b0;
      rs_q   <= '0;
      val_q  <= '0;
    end else if (cap_en) begin
      reg_q  <= src_reg_i;
      mode_q <= mode_in;
      byte_q <= byte_op_i;
      idx_q  <= (mode_in == AM_IDX);
      mem_q  <= !(cg_hit || mode_in == AM_REG);
      rs_q   <= rs_val_w;
      val_q  <= cg_hit ? cg_val : rs_val_w;
    end
  end

  // shadow program counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc_q <= '0;
    else if (cap_en) pc_q <= pc_i;
    else if (ext_en) pc_q <= pc_q + DATA_W'(WORD_BYTES);
  end

  // byte lane of the operand address
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lsb_q <= 1'b0;
    else if (rd_en) lsb_q <= rd_addr_w[0];
  end

  // outputs
  always_comb begin
    mem_req_o    = ext_en || rd_en;
    mem_addr_o   = ext_en ? pc_q : (rd_en ? rd_addr_w : '0);
    pc_wr_en_o   = ext_en || (rd_en && mode_q == AM_INC && reg_q == IDX_W'(PC_NUM));
    pc_wr_data_o = ext_en ? (pc_q + DATA_W'(WORD_BYTES)) : inc_w;
    rf_wr_en_o   = rd_en && mode_q == AM_INC && reg_q != IDX_W'(PC_NUM);
    rf_wr_idx_o  = reg_q;
    rf_wr_data_o = inc_w;
    done_o       = (state_q == S_DONE);
    operand_o    = done_o ? sel_val_w : '0;
  end

endmodule

// File: rtl/sopnd_seq_chk.sv
module sopnd_seq_chk #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [IDX_W-1:0]  src_reg_i,
  input logic [1:0]        src_mode_i,
  input logic              idle,
  input logic              mem_req_o,
  input logic [DATA_W-1:0] mem_addr_o,
  input logic              pc_wr_en_o,
  input logic [DATA_W-1:0] pc_wr_data_o,
  input logic              rf_wr_en_o,
  input logic [IDX_W-1:0]  rf_wr_idx_o,
  input logic [DATA_W-1:0] rf_wr_data_o,
  input logic              done_o
);

  localparam int WORD_BYTES = DATA_W / 8;

  // R3
  cg_r3_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && idle && src_reg_i == IDX_W'(3)) |=> (done_o && !mem_req_o && !pc_wr_en_o && !rf_wr_en_o));

  // R4
  cg_r2_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && idle && src_reg_i == IDX_W'(2) && src_mode_i[1]) |=> (done_o && !mem_req_o));

  // R1
  reg_mode_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && idle && src_mode_i == 2'b00) |=> (done_o && !mem_req_o));

  // R8
  pc_step_with_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr_en_o |-> (mem_req_o && pc_wr_data_o == mem_addr_o + DATA_W'(WORD_BYTES)));

  // R7
  autoinc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en_o |-> (mem_req_o && (rf_wr_data_o == mem_addr_o + DATA_W'(1) ||
                                  rf_wr_data_o == mem_addr_o + DATA_W'(WORD_BYTES))));

  // R7
  sp_word_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_wr_en_o && rf_wr_idx_o == IDX_W'(1)) |-> (rf_wr_data_o == mem_addr_o + DATA_W'(WORD_BYTES)));

  // R9
  idx_ext_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && idle && src_mode_i == 2'b01 && src_reg_i != IDX_W'(3)) |=> (mem_req_o && pc_wr_en_o));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R12
  done_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && mem_req_o));

endmodule

bind sopnd_seq sopnd_seq_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .src_reg_i    (src_reg_i),
  .src_mode_i   (src_mode_i),
  .idle         (idle_w),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .pc_wr_en_o   (pc_wr_en_o),
  .pc_wr_data_o (pc_wr_data_o),
  .rf_wr_en_o   (rf_wr_en_o),
  .rf_wr_idx_o  (rf_wr_idx_o),
  .rf_wr_data_o (rf_wr_data_o),
  .done_o       (done_o)
);

// File: tb/test_sopnd_seq.sv
module test_sopnd_seq;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  src_reg_i = '0;
  logic [1:0]  src_mode_i = '0;
  logic        byte_op_i = 1'b0;
  logic [15:0] pc_i = 16'h0020;
  logic [3:0]  rf_rd_idx_o;
  logic [15:0] rf_rd_data_i;
  logic        mem_req_o;
  logic [15:0] mem_addr_o;
  logic [15:0] mem_rdata_i = '0;
  logic        pc_wr_en_o;
  logic [15:0] pc_wr_data_o;
  logic        rf_wr_en_o;
  logic [3:0]  rf_wr_idx_o;
  logic [15:0] rf_wr_data_o;
  logic        done_o;
  logic [15:0] operand_o;

  logic [15:0] rf [16];
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sopnd_seq i_sopnd_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .src_reg_i(src_reg_i),
    .src_mode_i(src_mode_i), .byte_op_i(byte_op_i), .pc_i(pc_i),
    .rf_rd_idx_o(rf_rd_idx_o), .rf_rd_data_i(rf_rd_data_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i),
    .pc_wr_en_o(pc_wr_en_o), .pc_wr_data_o(pc_wr_data_o),
    .rf_wr_en_o(rf_wr_en_o), .rf_wr_idx_o(rf_wr_idx_o), .rf_wr_data_o(rf_wr_data_o),
    .done_o(done_o), .operand_o(operand_o)
  );

  function automatic logic [15:0] mword(input logic [15:0] a);
    return {a[15:1], 1'b0} ^ 16'h5A3C;
  endfunction

  always_comb rf_rd_data_i = rf[rf_rd_idx_o];

  always @(posedge clk) if (mem_req_o) mem_rdata_i <= mword(mem_addr_o);

  task automatic check(input string tag, input logic ok, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_case(input string tag, input logic [3:0] r, input logic [1:0] m, input logic b,
                          input logic [15:0] exp_val, input int exp_lat, input int exp_reads,
                          input logic exp_pcw, input logic [15:0] exp_pc,
                          input logic exp_rfw, input logic [3:0] exp_idx, input logic [15:0] exp_rfd);
    int lat = 0;
    int reads = 0;
    logic [15:0] val = '0;
    logic pcw = 1'b0;
    logic [15:0] pcd = '0;
    logic rfw = 1'b0;
    logic [3:0] rfi = '0;
    logic [15:0] rfd = '0;
    @(negedge clk);
    src_reg_i = r; src_mode_i = m; byte_op_i = b; start_i = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      start_i = 1'b0;
      if (mem_req_o) reads++;
      if (pc_wr_en_o) begin pcw = 1'b1; pcd = pc_wr_data_o; end
      if (rf_wr_en_o) begin rfw = 1'b1; rfi = rf_wr_idx_o; rfd = rf_wr_data_o; end
      if (done_o) begin lat = k; val = operand_o; break; end
    end
    check({tag, " operand"}, val == exp_val, val, exp_val);
    check({tag, " latency"}, lat == exp_lat, 16'(lat), 16'(exp_lat));
    check({tag, " reads"}, reads == exp_reads, 16'(reads), 16'(exp_reads));
    check({tag, " pc write"}, pcw == exp_pcw && (!exp_pcw || pcd == exp_pc), pcd, exp_pc);
    check({tag, " reg write"}, rfw == exp_rfw && (!exp_rfw || (rfd == exp_rfd && rfi == exp_idx)),
          rfd, exp_rfd);
  endtask

  task automatic t_reset();
    check("R12 reset done", done_o == 1'b0, 16'(done_o), 16'h0);
    check("R12 reset req", mem_req_o == 1'b0 && pc_wr_en_o == 1'b0 && rf_wr_en_o == 1'b0,
          16'(mem_req_o), 16'h0);
  endtask

  task automatic t_register();
    run_case("R1 reg R4", 4'd4, 2'b00, 1'b0, 16'h0040, 1, 0, 0, 0, 0, 0, 0);
    run_case("R1 reg PC", 4'd0, 2'b00, 1'b0, 16'h0020, 1, 0, 0, 0, 0, 0, 0);
    run_case("R2 byte reg R5", 4'd5, 2'b00, 1'b1, 16'h0081, 1, 0, 0, 0, 0, 0, 0);
    run_case("R2 byte const", 4'd3, 2'b11, 1'b1, 16'h00FF, 1, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_constants();
    run_case("R3 zero", 4'd3, 2'b00, 1'b0, 16'h0000, 1, 0, 0, 0, 0, 0, 0);
    run_case("R3 one", 4'd3, 2'b01, 1'b0, 16'h0001, 1, 0, 0, 0, 0, 0, 0);
    run_case("R3 two", 4'd3, 2'b10, 1'b0, 16'h0002, 1, 0, 0, 0, 0, 0, 0);
    run_case("R3 minus1", 4'd3, 2'b11, 1'b0, 16'hFFFF, 1, 0, 0, 0, 0, 0, 0);
    run_case("R4 four", 4'd2, 2'b10, 1'b0, 16'h0004, 1, 0, 0, 0, 0, 0, 0);
    run_case("R4 eight", 4'd2, 2'b11, 1'b0, 16'h0008, 1, 0, 0, 0, 0, 0, 0);
    run_case("R4 sr reg", 4'd2, 2'b00, 1'b0, 16'h0005, 1, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_indirect();
    run_case("R5 ind R4", 4'd4, 2'b10, 1'b0, mword(16'h0040), 2, 1, 0, 0, 0, 0, 0);
    run_case("R6 byte hi", 4'd6, 2'b10, 1'b1, {8'h00, mword(16'h0061)[15:8]}, 2, 1, 0, 0, 0, 0, 0);
    run_case("R6 byte lo", 4'd4, 2'b10, 1'b1, {8'h00, mword(16'h0040)[7:0]}, 2, 1, 0, 0, 0, 0, 0);
  endtask

  task automatic t_autoinc();
    run_case("R7 word inc", 4'd4, 2'b11, 1'b0, mword(16'h0040), 2, 1, 0, 0, 1, 4'd4, 16'h0042);
    run_case("R7 byte inc", 4'd6, 2'b11, 1'b1, {8'h00, mword(16'h0061)[15:8]}, 2, 1, 0, 0, 1, 4'd6, 16'h0062);
    run_case("R7 sp byte", 4'd1, 2'b11, 1'b1, {8'h00, mword(16'h0100)[7:0]}, 2, 1, 0, 0, 1, 4'd1, 16'h0102);
  endtask

  task automatic t_immediate();
    run_case("R8 imm", 4'd0, 2'b11, 1'b0, mword(16'h0020), 2, 1, 1, 16'h0022, 0, 0, 0);
  endtask

  task automatic t_indexed();
    logic [15:0] ext;
    ext = mword(16'h0020);
    run_case("R9 idx R4", 4'd4, 2'b01, 1'b0, mword(ext + 16'h0040), 3, 2, 1, 16'h0022, 0, 0, 0);
    run_case("R10 symbolic", 4'd0, 2'b01, 1'b0, mword(ext + 16'h0022), 3, 2, 1, 16'h0022, 0, 0, 0);
    run_case("R11 absolute", 4'd2, 2'b01, 1'b0, mword(ext), 3, 2, 1, 16'h0022, 0, 0, 0);
  endtask

  task automatic t_busy_start();
    int dones = 0;
    int first = 0;
    logic [15:0] val = '0;
    logic [15:0] exp_v;
    exp_v = mword(mword(16'h0020) + 16'h0040);
    @(negedge clk);
    src_reg_i = 4'd4; src_mode_i = 2'b01; byte_op_i = 1'b0; start_i = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (k == 1) begin src_reg_i = 4'd3; src_mode_i = 2'b00; start_i = 1'b1; end
      else start_i = 1'b0;
      if (done_o) begin dones++; if (first == 0) begin first = k; val = operand_o; end end
    end
    check("R12 busy start ignored count", dones == 1, 16'(dones), 16'd1);
    check("R12 busy start latency", first == 3, 16'(first), 16'd3);
    check("R12 busy start operand", val == exp_v, val, exp_v);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) rf[i] = 16'h0;
    rf[1] = 16'h0100; rf[2] = 16'h0005; rf[4] = 16'h0040;
    rf[5] = 16'h1281; rf[6] = 16'h0061; rf[7] = 16'h0070;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_register();
    t_constants();
    t_indirect();
    t_autoinc();
    t_immediate();
    t_indexed();
    t_busy_start();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule